// File: doc/BRIEF.md
# Transmit Statistics Counter Interrupt Bank

This block holds five transmit statistics counters and the interrupt status that goes with them. The counters track single-collision good frames, multiple-collision good frames, good packets, low-power-idle microseconds and low-power-idle transitions. Each counter has an increment strobe that comes from the transmit datapath. All five counters share one width, set by the `CNT_W` parameter. Typical values are 32 and 16, and any width from 8 to 32 is accepted.

A counter flags its status bit in two cases: when it reaches half of its range, and when it crosses its maximum. A global stop-rollover input chooses what happens at the maximum. With the input low, the counter wraps to zero. With the input high, the counter saturates at all-ones. Software reads the counters and the status word over a simple read bus with byte-lane enables. A status bit is cleared only by a read of its own counter that includes the lowest byte lane. A registered interrupt output reports that at least one status bit is set.

Top module: `txstat_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, all counters, the saturation state, every status bit, `rd_data_o` and `irq_o` are zero.
- R2: A counter goes up by one on each clock edge at which its strobe `inc_i[n]` is high and the counter is not saturated. Without a strobe the counter holds its value.
- R3: A counter whose increment takes it to 2^(CNT_W-1) (0x200 when CNT_W=10) sets its status bit at that same edge.
- R4: With `stop_roll_i` high, an increment that takes a counter to all-ones, or that arrives while the counter is already at all-ones, sets its status bit and saturates the counter. A saturated counter ignores every later strobe and sets no further status, whatever `stop_roll_i` does afterwards, until reset.
- R5: With `stop_roll_i` low, an increment of a counter at all-ones makes it zero and sets its status bit at the same edge.
- R6: Reads are accepted when `bus_en_i`=1 and `bus_we_i`=0. The read data appears on `rd_data_o` after the next edge and holds until the next read. Addresses 0 to 4 return counters 0 to 4, zero-extended: single-collision, multiple-collision, good packet, LPI microsecond, LPI transition. Address 5 returns the status word, with counter bits at positions 14, 15, 21, 26 and 27 in counter order and all other bits zero. Other addresses read as zero. Each byte lane whose `bus_be_i` bit is 0 reads as zero.
- R7: A read of counter address n with `bus_be_i[0]`=1 clears status bit n. A read of that address without lane 0, or a read of the status word, leaves the status unchanged.
- R8: An access with `bus_we_i`=1 changes no counter and no status bit, and it leaves `rd_data_o` unchanged.
- R9: When a set event and a clearing read of the same counter fall on the same edge, the status bit ends up set.
- R10: `irq_o` is a register. At each edge it takes the OR of the five status bits as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_i | input | 5 | Per-counter increment strobes |
| stop_roll_i | input | 1 | 1: saturate at all-ones, 0: wrap to zero |
| bus_en_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | 1 = write (ignored), 0 = read |
| bus_addr_i | input | 3 | Word address |
| bus_be_i | input | 4 | Byte-lane enables |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered OR of status bits |

## Verification
The assertions take strobes and bus controls to be clean synchronous levels that are valid at every edge after reset. They also assume that a saturated counter leaves saturation only through reset. The stimulus drives every input at the falling edge. It mixes random strobes, random lane enables and random addresses, including unused ones and writes. It holds `stop_roll_i` steady for long stretches so that counters really reach their half and full points. It applies reset periodically so that saturated counters come back into play.

// File: rtl/txstat_pkg.sv
// Shared constants for the transmit statistics interrupt bank.
// Assumes exactly five counters whose status bits have fixed positions.
package txstat_pkg;
    localparam int NUM_CNT = 5;
    localparam int BUS_W   = 32;
    localparam int BE_W    = BUS_W / 8;
    localparam int ADDR_W  = 3;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd5;

    typedef enum logic [ADDR_W-1:0] {
        CNT_SCOL   = 3'd0,
        CNT_MCOL   = 3'd1,
        CNT_GPKT   = 3'd2,
        CNT_LPI_US = 3'd3,
        CNT_LPI_TR = 3'd4
    } cnt_id_e;

    // Bit position of a counter's flag inside the status word.
    function automatic int status_bit_pos(input int idx);
        case (idx)
            0:       return 14;
            1:       return 15;
            2:       return 21;
            3:       return 26;
            4:       return 27;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/txstat_counter.sv
// One statistics counter with half-range and maximum crossing detection.
// Assumes CNT_W between 8 and 32. set_o is combinational and means that
// this edge's increment sets the status bit. Once saturated, the counter
// stays frozen until reset.
module txstat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             stop_roll_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_o,
    output logic             set_o
);
    localparam logic [CNT_W-1:0] HALF_V = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] MAX_V  = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sat_q, sat_d;
    logic             set_c;

    // Next count, saturation and set event from the strobe and the mode.
    always_comb begin
        cnt_d = cnt_q;
        sat_d = sat_q;
        set_c = 1'b0;
        if (inc_i && !sat_q) begin
            if (cnt_q == MAX_V) begin
                set_c = 1'b1;
                if (stop_roll_i) sat_d = 1'b1;
                else             cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_d == HALF_V) set_c = 1'b1;
                if (cnt_d == MAX_V && stop_roll_i) begin
                    set_c = 1'b1;
                    sat_d = 1'b1;
                end
            end
        end
    end

    // Count and saturation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sat_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            sat_q <= sat_d;
        end
    end

    assign cnt_o = cnt_q;
    assign sat_o = sat_q;
    assign set_o = set_c;
endmodule

// File: rtl/txstat_status.sv
// Status flags with set-over-clear priority and a registered interrupt.
// Assumes set and clear strobes are single-cycle qualified events.
module txstat_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o,
    output logic         irq_o
);
    logic [N-1:0] stat_q;
    logic         irq_q;

    // Flag update: a clear drops a bit, a same-edge set keeps it.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    // Interrupt line registered from the current flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |stat_q;
    end

    assign stat_o = stat_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/txstat_regread.sv
// Read side of the register bus: word select, lane masking, clear strobes.
// Assumes one access per cycle. Writes are accepted and dropped.
module txstat_regread
    import txstat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_en_i,
    input  logic                          bus_we_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic [BE_W-1:0]               bus_be_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
    input  logic [NUM_CNT-1:0]            stat_i,
    output logic [BUS_W-1:0]              rd_data_o,
    output logic [NUM_CNT-1:0]            clr_o
);
    logic [BUS_W-1:0] status_word;
    logic [BUS_W-1:0] sel_word;
    logic [BUS_W-1:0] lane_mask;
    logic [BUS_W-1:0] rd_q;
    logic             rd_acc;

    assign rd_acc = bus_en_i && !bus_we_i;

    // Scatter the flags into their fixed status word positions.
    always_comb begin
        status_word = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            status_word[status_bit_pos(i)] = stat_i[i];
        end
    end

    // Address decode to the selected word.
    always_comb begin
        sel_word = '0;
        if (bus_addr_i == STATUS_ADDR) begin
            sel_word = status_word;
        end else begin
            for (int i = 0; i < NUM_CNT; i++) begin
                if (bus_addr_i == ADDR_W'(i)) sel_word = BUS_W'(cnt_i[i]);
            end
        end
    end

    // Byte-lane mask from the enables.
    genvar b;
    generate
        for (b = 0; b < BE_W; b++) begin : g_lane
            assign lane_mask[8*b +: 8] = {8{bus_be_i[b]}};
        end
    endgenerate

    // One clear strobe per counter on a lane-0 read of its address.
    genvar c;
    generate
        for (c = 0; c < NUM_CNT; c++) begin : g_clr
            assign clr_o[c] = rd_acc && bus_be_i[0] && (bus_addr_i == ADDR_W'(c));
        end
    endgenerate

    // Read data register, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_acc) rd_q <= sel_word & lane_mask;
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/txstat_irq_bank.sv
// Top: five transmit statistics counters, status flags and read bus.
// Assumes strobes and bus signals are synchronous to clk.
module txstat_irq_bank
    import txstat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CNT-1:0]  inc_i,
    input  logic                stop_roll_i,
    input  logic                bus_en_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [BE_W-1:0]     bus_be_i,
    output logic [BUS_W-1:0]    rd_data_o,
    output logic                irq_o
);
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CNT-1:0]            sat_all;
    logic [NUM_CNT-1:0]            set_all;
    logic [NUM_CNT-1:0]            clr_all;
    logic [NUM_CNT-1:0]            stat_all;

    genvar i;
    generate
        for (i = 0; i < NUM_CNT; i++) begin : g_cnt
            txstat_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk         (clk),
                .rst_n       (rst_n),
                .inc_i       (inc_i[i]),
                .stop_roll_i (stop_roll_i),
                .cnt_o       (cnt_all[i]),
                .sat_o       (sat_all[i]),
                .set_o       (set_all[i])
            );
        end
    endgenerate

    txstat_status #(.N(NUM_CNT)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_all),
        .clr_i  (clr_all),
        .stat_o (stat_all),
        .irq_o  (irq_o)
    );

    txstat_regread #(.CNT_W(CNT_W)) u_regread (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en_i   (bus_en_i),
        .bus_we_i   (bus_we_i),
        .bus_addr_i (bus_addr_i),
        .bus_be_i   (bus_be_i),
        .cnt_i      (cnt_all),
        .stat_i     (stat_all),
        .rd_data_o  (rd_data_o),
        .clr_o      (clr_all)
    );
endmodule

// File: rtl/txstat_irq_bank_chk.sv
// Property checker for the interrupt bank, bound into the top module.
// Assumes saturation is left only through reset.
module txstat_irq_bank_chk
    import txstat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CNT-1:0]            inc_i,
    input logic                          stop_roll_i,
    input logic                          bus_en_i,
    input logic                          bus_we_i,
    input logic [ADDR_W-1:0]             bus_addr_i,
    input logic [BE_W-1:0]               bus_be_i,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CNT-1:0]            sat,
    input logic [NUM_CNT-1:0]            stat,
    input logic                          irq_o
);
    localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] MAX_V   = {CNT_W{1'b1}};

    AST_IRQ_FOLLOWS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat) |=> irq_o); // R10
    AST_IRQ_FOLLOWS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !(|stat) |=> !irq_o); // R10

    genvar i;
    generate
        for (i = 0; i < NUM_CNT; i++) begin : g_chk
            AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_i[i] && !sat[i] && cnt[i] != MAX_V) |=> cnt[i] == $past(cnt[i]) + 1'b1); // R2
            AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !inc_i[i] |=> $stable(cnt[i])); // R2
            AST_HALF_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_i[i] && !sat[i] && cnt[i] == HALF_M1) |=> stat[i]); // R3
            AST_SAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                sat[i] |=> (sat[i] && cnt[i] == MAX_V)); // R4
            AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_i[i] && !sat[i] && !stop_roll_i && cnt[i] == MAX_V) |=> (cnt[i] == '0 && stat[i])); // R5
            AST_LANE0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_en_i && !bus_we_i && bus_be_i[0] && bus_addr_i == ADDR_W'(i) && !inc_i[i]) |=> !stat[i]); // R7
            AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_en_i && bus_we_i && stat[i]) |=> stat[i]); // R8
        end
    endgenerate
endmodule

bind txstat_irq_bank txstat_irq_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_i       (inc_i),
    .stop_roll_i (stop_roll_i),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_be_i    (bus_be_i),
    .cnt         (cnt_all),
    .sat         (sat_all),
    .stat        (stat_all),
    .irq_o       (irq_o)
);

// File: tb/txstat_irq_bank_tb.sv
// Bench: directed corner cases followed by seeded random traffic, all
// compared with a reference model built from the requirements.
module txstat_irq_bank_tb;
    localparam int W     = 10;
    localparam int HALFV = 1 << (W - 1);
    localparam int MAXV  = (1 << W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  inc = '0;
    logic        stop = 1'b0;
    logic        en = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] rd_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int unsigned m_cnt[5];
    bit          m_sat[5];
    bit [4:0]    m_stat;
    bit          m_irq;
    bit [31:0]   m_rd;

    always #2.5 clk = ~clk;

    txstat_irq_bank #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .inc_i(inc), .stop_roll_i(stop),
        .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr), .bus_be_i(be),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic bit [31:0] stat_word(input bit [4:0] s);
        bit [31:0] w = '0;
        w[14] = s[0]; w[15] = s[1]; w[21] = s[2]; w[26] = s[3]; w[27] = s[4];
        return w;
    endfunction

    function automatic bit [31:0] lane_mask(input bit [3:0] b);
        bit [31:0] m = '0;
        for (int k = 0; k < 4; k++) if (b[k]) m[8*k +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic bit [31:0] exp_word(input bit [2:0] a);
        if (a < 3'd5)  return 32'(m_cnt[a]);
        if (a == 3'd5) return stat_word(m_stat);
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Update the reference model for one clock edge with the driven inputs.
    task automatic model_step();
        bit [4:0] clr = '0;
        bit [4:0] setv = '0;
        bit       nirq = |m_stat;
        if (en && !we) begin
            m_rd = exp_word(addr) & lane_mask(be);
            if (be[0] && addr < 3'd5) clr[addr] = 1'b1;
        end
        for (int i = 0; i < 5; i++) begin
            if (inc[i] && !m_sat[i]) begin
                if (m_cnt[i] == MAXV) begin
                    setv[i] = 1'b1;
                    if (stop) m_sat[i] = 1'b1;
                    else      m_cnt[i] = 0;
                end else begin
                    m_cnt[i]++;
                    if (m_cnt[i] == HALFV) setv[i] = 1'b1;
                    if (m_cnt[i] == MAXV && stop) begin
                        setv[i] = 1'b1;
                        m_sat[i] = 1'b1;
                    end
                end
            end
        end
        m_stat = (m_stat & ~clr) | setv;
        m_irq  = nirq;
    endtask

    // One cycle: drive at the falling edge, model the rising edge, compare.
    task automatic cyc(input string tag, input logic [4:0] i_inc, input logic i_en,
                       input logic i_we, input logic [2:0] i_addr, input logic [3:0] i_be);
        @(negedge clk);
        inc = i_inc; en = i_en; we = i_we; addr = i_addr; be = i_be;
        @(posedge clk);
        #1;
        model_step();
        chk({tag, " R6 rd_data"}, rd_data, m_rd);
        chk({tag, " R10 irq"}, {31'b0, irq}, {31'b0, m_irq});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; inc = '0; en = 1'b0; we = 1'b0; addr = '0; be = '0;
        repeat (2) @(posedge clk);
        #1;
        for (int i = 0; i < 5; i++) begin m_cnt[i] = 0; m_sat[i] = 1'b0; end
        m_stat = '0; m_irq = 1'b0; m_rd = '0;
        chk("R1 rd_data after reset", rd_data, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bump(input int n, input int idx, input string tag);
        for (int k = 0; k < n; k++) cyc(tag, 5'(1 << idx), 1'b0, 1'b0, 3'd0, 4'h0);
    endtask

    task automatic rd(input logic [2:0] a, input logic [3:0] b, input string tag);
        cyc(tag, 5'b0, 1'b1, 1'b0, a, b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd7321;
        void'($urandom(seed));
        do_reset();
        rd(3'd5, 4'hF, "R1 status read");
        chk("R1 status zero", rd_data, 32'h0);

        // R2 R3: half point of counter 0
        bump(HALFV - 1, 0, "R2 climb");
        rd(3'd5, 4'hF, "R3 before half");
        chk("R3 no flag below half", rd_data, 32'h0);
        bump(1, 0, "R3 reach half");
        rd(3'd5, 4'hF, "R3 after half");
        chk("R3 flag at half", rd_data, 32'h0000_4000);
        chk("R10 irq high", {31'b0, irq}, 32'h1);

        // R7 R8: lane 1 only does not clear, write does not clear, lane 0 clears
        rd(3'd0, 4'b0010, "R7 lane1 read");
        chk("R6 lane1 data", rd_data, 32'h0000_0200);
        rd(3'd5, 4'hF, "R7 status kept");
        chk("R7 lane1 no clear", rd_data, 32'h0000_4000);
        cyc("R8 write", 5'b0, 1'b1, 1'b1, 3'd0, 4'hF);
        cyc("R8 write status", 5'b0, 1'b1, 1'b1, 3'd5, 4'hF);
        chk("R8 rd_data held", rd_data, 32'h0000_4000);
        rd(3'd0, 4'hF, "R8 count kept");
        chk("R8 count unchanged", rd_data, 32'h0000_0200);
        rd(3'd5, 4'hF, "R7 after full read");
        chk("R7 lane0 cleared", rd_data, 32'h0);

        // R9: set and clear on the same edge for counter 1
        bump(HALFV - 1, 1, "R9 climb");
        cyc("R9 collide", 5'b00010, 1'b1, 1'b0, 3'd1, 4'b0001);
        chk("R9 read old low byte", rd_data, 32'h0000_00FF);
        rd(3'd5, 4'hF, "R9 status");
        chk("R9 set wins", rd_data, 32'h0000_8000);

        // R5: wrap of counter 2
        bump(MAXV, 2, "R5 climb");
        rd(3'd2, 4'hF, "R5 at max");
        chk("R5 max value", rd_data, 32'(MAXV));
        bump(1, 2, "R5 wrap");
        rd(3'd5, 4'hF, "R5 status");
        chk("R5 flag on wrap", rd_data, 32'h0020_8000);
        rd(3'd2, 4'hF, "R5 zero");
        chk("R5 wrapped to zero", rd_data, 32'h0);

        // R4: saturation of counter 3
        stop = 1'b1;
        bump(MAXV - 1, 3, "R4 climb");
        rd(3'd3, 4'h1, "R4 clear half flag");
        bump(1, 3, "R4 reach max");
        rd(3'd3, 4'h1, "R4 low byte");
        chk("R4 saturated low byte", rd_data, 32'h0000_00FF);
        stop = 1'b0;
        bump(5, 3, "R4 frozen");
        rd(3'd3, 4'hF, "R4 hold");
        chk("R4 held at max", rd_data, 32'(MAXV));
        rd(3'd5, 4'hF, "R4 status");
        chk("R4 no second flag", rd_data & 32'h0400_0000, 32'h0);
        do_reset();
        rd(3'd3, 4'hF, "R1 counter back");
        chk("R1 counter zero", rd_data, 32'h0);
        rd(3'd7, 4'hF, "R6 unused addr");
        chk("R6 unused addr zero", rd_data, 32'h0);

        // Random traffic with long steady mode stretches
        for (int blk = 0; blk < 8; blk++) begin
            stop = ($urandom % 3) == 0;
            for (int n = 0; n < 4000; n++) begin
                logic [4:0] ri = 5'($urandom);
                logic       re = ($urandom % 4) == 0;
                cyc("R2 random", ri, re, ($urandom % 5) == 0, 3'($urandom), 4'($urandom));
            end
            if (blk % 3 == 2) do_reset();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule